// File: doc/BRIEF.md
# Horizontal Sync Lock Filter

This block cleans up a raw horizontal sync stream before it reaches coast and vertical-sync logic. It keeps a phase counter that measures the distance, in pixel clocks, from the most recent reference pulse. A sync pulse counts as good only when it arrives inside a window centred one line period after that reference. Any other pulse is treated as noise.

Lock is granted after a programmable run of consecutive good pulses. Once the filter is locked, a leaky miss counter decides when lock is lost. The counter rises by one for every line whose window closes with no pulse and falls by one for every good pulse. While locked, the block produces a regenerated sync. This regenerated sync keeps to the line grid through dropouts and noise, and a select input routes it to the output in place of the raw sync.

The line period and all thresholds are configuration inputs. Measuring the line period lies outside the block.

Top module: `hsf_lock_filter`

## Requirements
- R1: While reset is asserted and right after it, `locked` and `hs_regen` are inactive (`hs_regen` = 0 for SYNC_POL=1), and `hs_out` equals `hs_raw`.
- R2: The active sync edge is the rising edge of `hs_raw` when SYNC_POL=1. The distance d of an edge is the number of clocks since the reference edge. The edge is accepted only when line_len − floor(win_width/2) ≤ d ≤ line_len + floor(win_width/2). The lower bound is clamped at 0.
- R3: While unlocked, the first edge with no reference becomes the reference. Each accepted edge after it adds one to a clean count. The accepted edge that brings the clean count to `lock_thr` sets `locked`, which is visible from the clock after that edge.
- R4: While unlocked, an out-of-window edge zeroes the clean count and becomes the new reference. A window that closes without an edge zeroes the clean count and drops the reference, so the next edge becomes a fresh reference.
- R5: While locked, an out-of-window edge is ignored. It changes neither the lock state nor the line phase.
- R6: While locked, `hs_regen` gives one single-clock pulse per line. The pulse comes one clock after an accepted edge, or one clock after the clock at distance line_len when no edge has arrived by then. A late accepted edge in the same line produces no second pulse.
- R7: When a locked window closes with no edge, the next expected position stays on the grid, exactly line_len clocks after the missed position.
- R8: While locked, the miss counter rises on each missed window and falls on each accepted edge, saturating at 0. The counter is cleared when lock is gained, and lock is dropped on the miss that brings it to `unlock_thr`.
- R9: On unlock, the reference is dropped, acquisition restarts from a zero clean count, and `hs_out` passes `hs_raw`.
- R10: `hs_out` carries `hs_regen` when `locked` and `regen_en` are both 1. Otherwise `hs_out` carries `hs_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_raw | input | 1 | Raw horizontal sync |
| line_len | input | LINE_W | Expected line period in clocks |
| lock_thr | input | CNT_W | Consecutive good pulses needed to lock |
| unlock_thr | input | CNT_W | Miss-counter value that drops lock |
| win_width | input | CNT_W | Acceptance window width in clocks |
| regen_en | input | 1 | Route regenerated sync to `hs_out` while locked |
| hs_out | output | 1 | Sync for downstream logic |
| hs_regen | output | 1 | Regenerated sync pulse |
| locked | output | 1 | Lock status |

## Verification
The bench builds the block with LINE_W=10, CNT_W=8 and SYNC_POL=1. It drives a line period of 40, a window width of 8, a lock threshold of 4 and an unlock threshold of 3. With these values, lock and loss of lock both happen within a few lines. Both window borders (36 and 44 clocks) sit a few clocks from the centre, so edges exactly on the borders and one clock beyond them are cheap to produce. The small unlock threshold also lets a short miss, miss, good, miss, miss sequence show the leaky count up and down before the counter reaches the threshold.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
   // Classified outcome of one clock for the lock controller.
   typedef struct packed {
      logic start;   // first edge with no reference
      logic acc;     // edge inside the window
      logic noise;   // edge outside the window
      logic miss;    // window closed without an edge
   } hsf_evt_t;

   localparam int HSF_MIN_LINE_W = 2;
   localparam int HSF_MAX_LINE_W = 24;
endpackage

// File: rtl/hsf_edge_det.sv
module hsf_edge_det #(
   parameter bit SYNC_POL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic edge_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= ~SYNC_POL;
      else        prev_q <= sync_in;
   end

   generate
      if (SYNC_POL) begin : g_rise
         assign edge_o = sync_in & ~prev_q;
      end else begin : g_fall
         assign edge_o = ~sync_in & prev_q;
      end
   endgenerate
endmodule

// File: rtl/hsf_window.sv
module hsf_window #(
   parameter int LINE_W = 12,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_len,
   input  logic [CNT_W-1:0]  win_width,
   input  logic              run,
   input  logic              ld_edge,
   input  logic              ld_virt,
   output logic              in_win,
   output logic              at_expect,
   output logic              at_close
);
   localparam int PW = LINE_W + 1;

   logic [PW-1:0] half_x, line_x, hi, lo, pos_q;

   assign half_x = PW'(win_width >> 1);
   assign line_x = {1'b0, line_len};
   assign hi     = line_x + half_x;
   assign lo     = (line_x > half_x) ? (line_x - half_x) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)                pos_q <= '0;
      else if (ld_edge)          pos_q <= PW'(1);
      else if (ld_virt)          pos_q <= half_x + PW'(1);
      else if (!run)             pos_q <= '0;
      else if (pos_q != '1)      pos_q <= pos_q + PW'(1);
   end

   assign in_win    = run && (pos_q >= lo) && (pos_q <= hi);
   assign at_expect = run && (pos_q == line_x);
   assign at_close  = run && (pos_q == hi);
endmodule

// File: rtl/hsf_lock_ctl.sv
module hsf_lock_ctl
   import hsf_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_edge,
   input  logic             in_win,
   input  logic             at_expect,
   input  logic             at_close,
   input  logic [CNT_W-1:0] lock_thr,
   input  logic [CNT_W-1:0] unlock_thr,
   output logic             have_ref,
   output logic             ld_edge,
   output logic             ld_virt,
   output logic             locked,
   output logic             fire,
   output logic [CNT_W-1:0] clean_cnt,
   output logic [CNT_W-1:0] miss_cnt
);
   hsf_evt_t        ev;
   logic            pulsed_q;
   logic [CNT_W:0]  clean_inc, miss_inc;
   logic            lock_hit, unlock_hit;

   always_comb begin
      ev.start = !have_ref && sync_edge;
      ev.acc   = have_ref && sync_edge && in_win;
      ev.noise = have_ref && sync_edge && !in_win;
      ev.miss  = have_ref && at_close && !sync_edge;
   end

   assign clean_inc  = {1'b0, clean_cnt} + (CNT_W+1)'(1);
   assign miss_inc   = {1'b0, miss_cnt} + (CNT_W+1)'(1);
   assign lock_hit   = clean_inc >= {1'b0, lock_thr};
   assign unlock_hit = miss_inc >= {1'b0, unlock_thr};

   assign ld_edge = ev.start | ev.acc | (ev.noise & !locked);
   assign ld_virt = ev.miss & locked & !unlock_hit;
   assign fire    = locked && !pulsed_q && (ev.acc || at_expect);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_ref  <= 1'b0;
         locked    <= 1'b0;
         clean_cnt <= '0;
         miss_cnt  <= '0;
         pulsed_q  <= 1'b0;
      end else begin
         if (locked) begin
            if (ev.acc) begin
               if (miss_cnt != '0) miss_cnt <= miss_cnt - CNT_W'(1);
            end else if (ev.miss) begin
               if (unlock_hit) begin
                  locked    <= 1'b0;
                  have_ref  <= 1'b0;
                  miss_cnt  <= '0;
                  clean_cnt <= '0;
               end else begin
                  miss_cnt <= miss_inc[CNT_W-1:0];
               end
            end
         end else begin
            if (ev.start) begin
               have_ref  <= 1'b1;
               clean_cnt <= '0;
            end else if (ev.acc) begin
               if (lock_hit) begin
                  locked    <= 1'b1;
                  clean_cnt <= '0;
                  miss_cnt  <= '0;
               end else begin
                  clean_cnt <= clean_inc[CNT_W-1:0];
               end
            end else if (ev.noise) begin
               clean_cnt <= '0;
            end else if (ev.miss) begin
               have_ref  <= 1'b0;
               clean_cnt <= '0;
            end
         end
         if (ev.acc || ev.miss) pulsed_q <= 1'b0;
         else if (fire)         pulsed_q <= 1'b1;
      end
   end
endmodule

// File: rtl/hsf_lock_filter.sv
module hsf_lock_filter
   import hsf_pkg::*;
#(
   parameter int LINE_W   = 12,
   parameter int CNT_W    = 8,
   parameter bit SYNC_POL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_raw,
   input  logic [LINE_W-1:0] line_len,
   input  logic [CNT_W-1:0]  lock_thr,
   input  logic [CNT_W-1:0]  unlock_thr,
   input  logic [CNT_W-1:0]  win_width,
   input  logic              regen_en,
   output logic              hs_out,
   output logic              hs_regen,
   output logic              locked
);
   generate
      if (LINE_W < HSF_MIN_LINE_W || LINE_W > HSF_MAX_LINE_W) begin : g_bad_line_w
         $error("hsf_lock_filter: LINE_W out of range");
      end
      if (CNT_W < 1 || CNT_W > LINE_W) begin : g_bad_cnt_w
         $error("hsf_lock_filter: CNT_W must be 1..LINE_W");
      end
   endgenerate

   logic             w_edge, w_in_win, w_at_expect, w_at_close;
   logic             c_have_ref, c_ld_edge, c_ld_virt, c_fire;
   logic [CNT_W-1:0] c_clean, c_miss;
   logic             regen_q;

   hsf_edge_det #(.SYNC_POL(SYNC_POL)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (hs_raw),
      .edge_o  (w_edge)
   );

   hsf_window #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_len  (line_len),
      .win_width (win_width),
      .run       (c_have_ref),
      .ld_edge   (c_ld_edge),
      .ld_virt   (c_ld_virt),
      .in_win    (w_in_win),
      .at_expect (w_at_expect),
      .at_close  (w_at_close)
   );

   hsf_lock_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_edge  (w_edge),
      .in_win     (w_in_win),
      .at_expect  (w_at_expect),
      .at_close   (w_at_close),
      .lock_thr   (lock_thr),
      .unlock_thr (unlock_thr),
      .have_ref   (c_have_ref),
      .ld_edge    (c_ld_edge),
      .ld_virt    (c_ld_virt),
      .locked     (locked),
      .fire       (c_fire),
      .clean_cnt  (c_clean),
      .miss_cnt   (c_miss)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) regen_q <= 1'b0;
      else        regen_q <= c_fire;
   end

   generate
      if (SYNC_POL) begin : g_regen_hi
         assign hs_regen = regen_q;
      end else begin : g_regen_lo
         assign hs_regen = ~regen_q;
      end
   endgenerate

   assign hs_out = (locked && regen_en) ? hs_regen : hs_raw;
endmodule

// File: rtl/hsf_lock_filter_chk.sv
module hsf_lock_filter_chk #(
   parameter int LINE_W = 12,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LINE_W-1:0] line_len,
   input logic              locked,
   input logic              regen_q,
   input logic              sync_edge,
   input logic              in_win,
   input logic              at_close,
   input logic              have_ref,
   input logic [CNT_W-1:0]  clean_cnt,
   input logic [CNT_W-1:0]  miss_cnt
);
   // R6: a regenerated pulse follows a clock in which the filter was locked
   a_r6_regen_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      regen_q |-> $past(locked));

   // R6: regenerated pulses last one clock
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (regen_q && line_len > LINE_W'(1)) |=> !regen_q);

   // R3: lock is gained only on an accepted edge
   a_r3_lock_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(sync_edge && in_win));

   // R8: miss counter starts from zero when lock is gained
   a_r8_lock_clears_miss: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> (miss_cnt == '0));

   // R9: lock is lost only at a window that closed empty
   a_r9_unlock_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(at_close && !sync_edge));

   // R4: an out-of-window edge before lock zeroes the clean count
   a_r4_noise_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && have_ref && sync_edge && !in_win) |=> (clean_cnt == '0));
endmodule

bind hsf_lock_filter hsf_lock_filter_chk #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_len  (line_len),
   .locked    (locked),
   .regen_q   (regen_q),
   .sync_edge (w_edge),
   .in_win    (w_in_win),
   .at_close  (w_at_close),
   .have_ref  (c_have_ref),
   .clean_cnt (c_clean),
   .miss_cnt  (c_miss)
);

// File: tb/test_hsf_lock_filter.sv
`timescale 1ns/1ps
module test_hsf_lock_filter;
   localparam int LINE_W = 10;
   localparam int CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              hs_raw = 1'b0;
   logic [LINE_W-1:0] line_len = 10'd40;
   logic [CNT_W-1:0]  lock_thr = 8'd4;
   logic [CNT_W-1:0]  unlock_thr = 8'd3;
   logic [CNT_W-1:0]  win_width = 8'd8;
   logic              regen_en = 1'b1;
   logic              hs_out, hs_regen, locked;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   hsf_lock_filter #(.LINE_W(LINE_W), .CNT_W(CNT_W), .SYNC_POL(1'b1)) i_hsf_lock_filter (
      .clk(clk), .rst_n(rst_n), .hs_raw(hs_raw), .line_len(line_len),
      .lock_thr(lock_thr), .unlock_thr(unlock_thr), .win_width(win_width),
      .regen_en(regen_en), .hs_out(hs_out), .hs_regen(hs_regen), .locked(locked)
   );

   // gap: clocks since previous slot; pulse: raise raw; expected {locked, regen, out}
   typedef struct packed {
      logic [7:0] gap;
      logic       pulse;
      logic [2:0] exp;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{8'd10, 1'b1, 3'b001},  // R3 first edge becomes reference
      '{8'd40, 1'b1, 3'b001},  // R3 clean 1
      '{8'd40, 1'b1, 3'b001},  // R3 clean 2
      '{8'd20, 1'b1, 3'b001},  // R4 out-of-window, count zeroed
      '{8'd40, 1'b1, 3'b001},  // R3 clean 1
      '{8'd36, 1'b1, 3'b001},  // R2 lower border accepted
      '{8'd44, 1'b1, 3'b001},  // R2 upper border accepted
      '{8'd40, 1'b1, 3'b100},  // R3 fourth clean edge locks
      '{8'd40, 1'b1, 3'b111},  // R6 pulse on accepted edge
      '{8'd38, 1'b1, 3'b111},  // R6 early edge
      '{8'd40, 1'b0, 3'b111},  // R7 missing, regenerated
      '{8'd40, 1'b0, 3'b111},  // R8 second miss
      '{8'd42, 1'b1, 3'b100},  // R6 late edge, no second pulse
      '{8'd40, 1'b0, 3'b111},  // R8 leaky count back up
      '{8'd40, 1'b0, 3'b111},  // R8 reaches threshold at close
      '{8'd40, 1'b1, 3'b001},  // R9 unlocked, raw passed
      '{8'd30, 1'b1, 3'b001},  // R4 noise sets new reference
      '{8'd40, 1'b1, 3'b001},  // R3
      '{8'd40, 1'b1, 3'b001},  // R3
      '{8'd40, 1'b1, 3'b001},  // R3
      '{8'd40, 1'b1, 3'b100},  // R3 relock
      '{8'd20, 1'b1, 3'b100},  // R5 noise ignored while locked
      '{8'd20, 1'b1, 3'b111},  // R5 phase kept from reference
      '{8'd40, 1'b1, 3'b111}   // R10 regen routed to output
   };

   task automatic check3(input string tag, input logic [2:0] got, input logic [2:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s {locked,regen,out} actual=%b expected=%b", tag, got, exp);
      end
   endtask

   // one slot: gap clocks after previous raise point, optional raise, sample after edge
   task automatic slot(input int gap, input bit pulse, input logic [2:0] exp, input string tag);
      for (int k = 2; k <= gap; k++) begin
         @(negedge clk);
         hs_raw = pulse && (k == gap);
      end
      @(negedge clk);
      check3(tag, {locked, hs_regen, hs_out}, exp);
      hs_raw = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      hs_raw = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state, raw passthrough
      check3("R1 in reset", {locked, hs_regen, hs_out}, 3'b001);
      hs_raw = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check3("R1 after reset", {locked, hs_regen, hs_out}, 3'b000);

      for (int i = 0; i < NV; i++) begin
         slot(int'(VECS[i].gap), VECS[i].pulse, VECS[i].exp, $sformatf("R%0d vector %0d", 2 + (i % 9), i));
      end

      // R10 select off: raw reaches output while regen still runs
      regen_en = 1'b0;
      slot(40, 1'b0, 3'b110, "R10 regen_en=0 missing line");
      slot(40, 1'b1, 3'b111, "R10 regen_en=0 edge line");
      regen_en = 1'b1;

      // R4 an empty window before lock drops the reference
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      slot(10, 1'b1, 3'b001, "R4 ref");
      slot(40, 1'b1, 3'b001, "R4 clean1");
      slot(40, 1'b1, 3'b001, "R4 clean2");
      slot(50, 1'b0, 3'b000, "R4 window closed empty");
      slot(30, 1'b1, 3'b001, "R4 fresh reference");
      slot(40, 1'b1, 3'b001, "R4 clean1 after drop");
      slot(40, 1'b1, 3'b001, "R4 clean2 after drop");
      slot(40, 1'b1, 3'b001, "R4 clean3 not yet locked");
      slot(40, 1'b1, 3'b100, "R3 lock after restart");

      // R2 one clock past the upper border is rejected; R7 grid held
      slot(45, 1'b1, 3'b100, "R2 edge at 45 rejected");
      slot(35, 1'b1, 3'b111, "R7 edge on grid after miss");

      summary();
   end
endmodule